// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block times a successive-approximation converter from the digital side. It produces a converter clock by dividing the input clock. It holds the sampling phase for a programmable number of those converter clocks. It then spends one converter clock on each result bit, plus two clocks of overhead. The analog front end is represented by a 12-bit input, `adc_result`. That input is taken as valid at the moment a conversion ends.

A conversion is launched in one of two ways. In software mode, only a write to control group 0 launches one. In hardware mode, an external trigger pulse launches one, and the control groups take turns in round-robin order. Each control group stores a channel number and an interrupt enable.

The block shows whether it is busy and which group and channel are active. When a conversion ends, it delivers a one-cycle done strobe together with the group, the channel and the data. A continuous setting relaunches the finished group automatically.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `cfg_div` codes 0/1/2/3 divide the input clock by D = 1/2/4/8. For a conversion launched at clock edge t, `done` is registered at edge t + D*(S+N+2), where S is the sample length and N is the resolution in converter clocks.
- R2: With `cfg_long`=0, `cfg_smp` codes 0/1/2/3 give S = 2/4/6/8. With `cfg_long`=1 they give S = 12/16/20/24. `in_sample` is high for exactly the first D*S input cycles of a conversion.
- R3: `cfg_res` code 0 gives N=8, code 1 gives N=10, and codes 2 and 3 give N=12. `done_data` is `adc_result` shifted right by 12-N, zero-extended.
- R4: With `cfg_hwtrig`=0, a write to group 0 launches a conversion of group 0, and `busy` is high from the next cycle. A write to any other group never launches one. `hw_trig` is ignored.
- R5: With `cfg_hwtrig`=1, an `hw_trig` pulse while idle launches the group at the round-robin pointer. The pointer starts at 0 after reset and advances 0,1,...,NGRP-1,0 after each such launch. Group writes never launch a conversion in this mode.
- R6: An `hw_trig` pulse while `busy` is high is ignored and does not advance the pointer.
- R7: In hardware mode, writing the active group while busy aborts the conversion: `busy` is low the next cycle and no `done` follows. In software mode, writing group 0 while busy restarts it with the new channel.
- R8: Writing a group other than the active one during a conversion changes neither its timing nor its reported channel.
- R9: `done` is a single-cycle pulse. It carries `done_grp` and `done_chan` of the finished group. `done_irq` equals `done` AND that group's interrupt enable.
- R10: With `cfg_cont`=1, a finished group is relaunched at the same edge, so `busy` stays high. Clearing `cfg_cont` lets the running conversion finish, and the block then stops.
- R11: After reset, `busy`, `done`, `done_irq` and `in_sample` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hwtrig | input | 1 | 1 selects hardware trigger mode, 0 selects software mode |
| cfg_cont | input | 1 | Continuous relaunch enable |
| cfg_long | input | 1 | Long sample-time encoding |
| cfg_smp | input | 2 | Sample length code |
| cfg_div | input | 2 | Converter clock divider code |
| cfg_res | input | 2 | Resolution code |
| grp_wr | input | 1 | Group write strobe |
| grp_wr_idx | input | GW | Index of the group being written |
| grp_wr_chan | input | CH_W | Channel number to store (0..31) |
| grp_wr_ie | input | 1 | Interrupt enable to store |
| hw_trig | input | 1 | Hardware trigger pulse |
| adc_result | input | 12 | Front-end result, MSB-aligned, valid at conversion end |
| busy | output | 1 | Conversion in progress |
| in_sample | output | 1 | Sample phase in progress |
| act_grp | output | GW | Group controlling the current conversion |
| act_chan | output | CH_W | Channel of the active group |
| done | output | 1 | Conversion finished strobe |
| done_grp | output | GW | Group of the finished conversion |
| done_chan | output | CH_W | Channel of the finished conversion |
| done_data | output | 12 | Right-justified result |
| done_irq | output | 1 | Interrupt request for the finished conversion |

## Verification
The bound checks in the divider and phase timer assume that `cfg_div`, `cfg_smp`, `cfg_long` and `cfg_res` do not change while `busy` is high. The stimulus changes configuration only after the scoreboard queue has drained and `busy` is low. The single-cycle `done` check also relies on every conversion lasting at least twelve cycles, which holds for every legal code. All strobes are driven one cycle wide on falling edges. No group write is made in the cycle where a conversion ends, so no collision between an abort and a completion is exercised.

// File: rtl/adc_seq_pkg.sv
// Shared widths, group record and code decoders for the conversion sequencer.
// Assumes result data is 12 bits wide and channel numbers fit in 5 bits.
package adc_seq_pkg;
    localparam int RES_W = 12;
    localparam int CNT_W = 6;
    localparam int CH_W  = 5;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            ie;
    } grp_cfg_t;

    // Sample length in converter clocks for a code and mode.
    function automatic logic [CNT_W-1:0] smp_clocks(input logic [1:0] code, input logic lng);
        logic [CNT_W-1:0] step;
        step = {{(CNT_W-4){1'b0}}, code, 2'b00};
        if (lng)
            return CNT_W'(12) + step;
        else
            return CNT_W'(2) + (step >> 1);
    endfunction

    // Result bits for a resolution code; code 3 is treated as 12 bits.
    function automatic logic [3:0] res_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd8;
            2'd1:    return 4'd10;
            default: return 4'd12;
        endcase
    endfunction
endpackage

// File: rtl/adc_clk_div.sv
// Converter clock enable generator: one tick every 1, 2, 4 or 8 input cycles.
// Assumes div_code is stable while run is high; the phase restarts on restart.
module adc_clk_div #(
    parameter int CW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div_code,
    output logic       tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'((1 << div_code) - 1);
    assign tick = run && (cnt == lim);

    // Prescaler counter, cleared when idle, on restart and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(div_code)) |-> (cnt <= lim)); // R1
endmodule

// File: rtl/adc_phase_timer.sv
// Counts converter clocks through the sample and conversion phases.
// Assumes both lengths are stable while run is high and their sum is nonzero.
module adc_phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] smp_len,
    input  logic [CW-1:0] conv_len,
    output logic          in_sample,
    output logic          last
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] total;

    assign total     = smp_len + conv_len;
    assign last      = tick && (cnt == total - 1'b1);
    assign in_sample = run && (cnt < smp_len);

    // Converter clock counter across both phases.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(total)) |-> (cnt < total)); // R1
endmodule

// File: rtl/adc_grp_bank.sv
// Control group storage plus round-robin pointer for hardware launches.
// Assumes writes may target any group at any time; adv pulses once per launch.
module adc_grp_bank
    import adc_seq_pkg::*;
#(
    parameter int NGRP = 4,
    parameter int GW   = $clog2(NGRP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [GW-1:0]   wr_idx,
    input  logic [CH_W-1:0] wr_chan,
    input  logic            wr_ie,
    input  logic [GW-1:0]   rd_idx,
    output logic [CH_W-1:0] rd_chan,
    output logic            rd_ie,
    input  logic            adv,
    output logic [GW-1:0]   ptr
);
    grp_cfg_t regs [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // Holds one group's channel and interrupt enable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr && (wr_idx == GW'(g)))
                regs[g] <= '{chan: wr_chan, ie: wr_ie};
        end
    end

    assign rd_chan = regs[rd_idx].chan;
    assign rd_ie   = regs[rd_idx].ie;

    // Round-robin pointer stepping on each hardware launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == GW'(NGRP - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the conversion sequencer: launch, abort, completion and relaunch control.
// Assumes configuration inputs stay stable during a conversion and adc_result is
// valid in the cycle where the last converter clock of a conversion ends.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NGRP = 4,
    parameter int GW   = $clog2(NGRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hwtrig,
    input  logic             cfg_cont,
    input  logic             cfg_long,
    input  logic [1:0]       cfg_smp,
    input  logic [1:0]       cfg_div,
    input  logic [1:0]       cfg_res,
    input  logic             grp_wr,
    input  logic [GW-1:0]    grp_wr_idx,
    input  logic [CH_W-1:0]  grp_wr_chan,
    input  logic             grp_wr_ie,
    input  logic             hw_trig,
    input  logic [RES_W-1:0] adc_result,
    output logic             busy,
    output logic             in_sample,
    output logic [GW-1:0]    act_grp,
    output logic [CH_W-1:0]  act_chan,
    output logic             done,
    output logic [GW-1:0]    done_grp,
    output logic [CH_W-1:0]  done_chan,
    output logic [RES_W-1:0] done_data,
    output logic             done_irq
);
    logic             tick, last, act_ie;
    logic [GW-1:0]    rr_ptr;
    logic [3:0]       nbits;
    logic [CNT_W-1:0] smp_len, conv_len;
    logic             start_sw, start_hw, abort_hw, finish, restart;

    assign nbits    = res_bits(cfg_res);
    assign smp_len  = smp_clocks(cfg_smp, cfg_long);
    assign conv_len = CNT_W'(nbits) + CNT_W'(2);

    assign start_sw = !cfg_hwtrig && grp_wr && (grp_wr_idx == '0);
    assign start_hw = cfg_hwtrig && hw_trig && !busy;
    assign abort_hw = cfg_hwtrig && busy && grp_wr && (grp_wr_idx == act_grp);
    assign finish   = busy && last && !abort_hw && !start_sw;
    assign restart  = start_sw || start_hw || (finish && cfg_cont);

    adc_clk_div #(.CW(3)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(restart),
        .div_code(cfg_div), .tick(tick)
    );

    adc_phase_timer #(.CW(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(restart), .tick(tick),
        .smp_len(smp_len), .conv_len(conv_len), .in_sample(in_sample), .last(last)
    );

    adc_grp_bank #(.NGRP(NGRP), .GW(GW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(grp_wr), .wr_idx(grp_wr_idx),
        .wr_chan(grp_wr_chan), .wr_ie(grp_wr_ie), .rd_idx(act_grp),
        .rd_chan(act_chan), .rd_ie(act_ie), .adv(start_hw), .ptr(rr_ptr)
    );

    // Activity and owning group: launch, abort and end of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            act_grp <= '0;
        end else if (start_sw) begin
            busy    <= 1'b1;
            act_grp <= '0;
        end else if (start_hw) begin
            busy    <= 1'b1;
            act_grp <= rr_ptr;
        end else if (abort_hw) begin
            busy    <= 1'b0;
        end else if (finish && !cfg_cont) begin
            busy    <= 1'b0;
        end
    end

    // Completion strobe and captured result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            done_irq  <= 1'b0;
            done_grp  <= '0;
            done_chan <= '0;
            done_data <= '0;
        end else begin
            done     <= finish;
            done_irq <= finish && act_ie;
            if (finish) begin
                done_grp  <= act_grp;
                done_chan <= act_chan;
                done_data <= adc_result >> (4'(RES_W) - nbits);
            end
        end
    end

    AST_SW_GROUP0: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_hwtrig && !(grp_wr && grp_wr_idx == '0)) |=> !busy); // R4
    AST_HW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_hwtrig && hw_trig) |=> (busy && act_grp == $past(rr_ptr))); // R5
    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_hwtrig && hw_trig) |=> $stable(rr_ptr)); // R6
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_hwtrig && grp_wr && grp_wr_idx == act_grp) |=> (!busy && !done)); // R7
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> done); // R9
    AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy == $past(cfg_cont))); // R10
endmodule

// File: tb/sim_adc_seq_ctrl.sv
// Scoreboard bench: the driver queues expected completions, the monitor matches them.
module sim_adc_seq_ctrl;
    localparam int NGRP = 4;
    localparam int GW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hwtrig = 0, cfg_cont = 0, cfg_long = 0;
    logic [1:0] cfg_smp = 0, cfg_div = 0, cfg_res = 2;
    logic grp_wr = 0, grp_wr_ie = 0, hw_trig = 0;
    logic [GW-1:0] grp_wr_idx = 0;
    logic [4:0] grp_wr_chan = 0;
    logic [11:0] adc_result = 0;
    logic busy, in_sample, done, done_irq;
    logic [GW-1:0] act_grp, done_grp;
    logic [4:0] act_chan, done_chan;
    logic [11:0] done_data;

    adc_seq_ctrl #(.NGRP(NGRP), .GW(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hwtrig(cfg_hwtrig), .cfg_cont(cfg_cont),
        .cfg_long(cfg_long), .cfg_smp(cfg_smp), .cfg_div(cfg_div), .cfg_res(cfg_res),
        .grp_wr(grp_wr), .grp_wr_idx(grp_wr_idx), .grp_wr_chan(grp_wr_chan),
        .grp_wr_ie(grp_wr_ie), .hw_trig(hw_trig), .adc_result(adc_result),
        .busy(busy), .in_sample(in_sample), .act_grp(act_grp), .act_chan(act_chan),
        .done(done), .done_grp(done_grp), .done_chan(done_chan),
        .done_data(done_data), .done_irq(done_irq)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    cyc;
        int    grp;
        int    chan;
        int    data;
        int    irq;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   drv_cyc = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int lat(input int dv, input int smp, input int lng, input int res);
        int s, n;
        s = lng ? 12 + 4 * smp : 2 + 2 * smp;
        n = (res == 0) ? 8 : (res == 1) ? 10 : 12;
        return (1 << dv) * (s + n + 2);
    endfunction

    function automatic int rdata(input int raw, input int res);
        int n;
        n = (res == 0) ? 8 : (res == 1) ? 10 : 12;
        return raw >> (12 - n);
    endfunction

    task automatic push(input int at, input int g, input int ch, input int d, input int irq, input string req);
        exp_t e;
        e.cyc = at; e.grp = g; e.chan = ch; e.data = d; e.irq = irq; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: every done must match the head of the queue in cycle and fields.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7/R4 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc == e.cyc, {e.req, " done cycle"}, cyc, e.cyc);
                    chk(done_grp == e.grp && done_chan == e.chan,
                        {e.req, " R9 grp*32+chan"}, done_grp * 32 + done_chan, e.grp * 32 + e.chan);
                    chk(done_data == e.data, {e.req, " R3 data"}, done_data, e.data);
                    chk(done_irq == e.irq, {e.req, " R9 irq"}, done_irq, e.irq);
                end
            end else if (exp_q.size() != 0 && cyc > exp_q[0].cyc) begin
                chk(0, {exp_q[0].req, " missing done"}, cyc, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic wr_grp(input int idx, input int ch, input int ie);
        @(negedge clk);
        grp_wr = 1; grp_wr_idx = GW'(idx); grp_wr_chan = 5'(ch); grp_wr_ie = ie[0];
        drv_cyc = cyc;
        @(negedge clk);
        grp_wr = 0;
    endtask

    task automatic trig();
        @(negedge clk);
        hw_trig = 1;
        drv_cyc = cyc;
        @(negedge clk);
        hw_trig = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
            summary();
        end
    end

    initial begin
        int L;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !done_irq && !in_sample, "R11 reset outputs", busy, 0);
        rst_n = 1;

        // R1 R3 R9: fastest settings, 12-bit, interrupt enabled
        adc_result = 12'hABC;
        L = lat(0, 0, 0, 2);
        wr_grp(0, 5, 1);
        push(drv_cyc + 1 + L, 0, 5, rdata(12'hABC, 2), 1, "R1 div1 short2 12b");
        chk(busy == 1, "R4 busy after group0 write", busy, 1);
        drain();

        // R1 R2 R3: divide by 4, long 24, 8-bit, with sample phase timing
        cfg_div = 2; cfg_smp = 3; cfg_long = 1; cfg_res = 0;
        adc_result = 12'hF5A;
        L = lat(2, 3, 1, 0);
        wr_grp(0, 17, 0);
        push(drv_cyc + 1 + L, 0, 17, rdata(12'hF5A, 0), 0, "R1 div4 long24 8b");
        chk(in_sample == 1, "R2 sample phase start", in_sample, 1);
        repeat (95) @(negedge clk);
        chk(in_sample == 1, "R2 last sample cycle", in_sample, 1);
        @(negedge clk);
        chk(in_sample == 0, "R2 sample phase over", in_sample, 0);
        drain();

        // R1 R3: divide by 2, short 4, 10-bit, channel 31
        cfg_div = 1; cfg_smp = 1; cfg_long = 0; cfg_res = 1;
        adc_result = 12'h3FF;
        L = lat(1, 1, 0, 1);
        wr_grp(0, 31, 1);
        push(drv_cyc + 1 + L, 0, 31, rdata(12'h3FF, 1), 1, "R1 div2 short4 10b");
        drain();

        // R4: other-group write and hardware trigger do nothing in software mode
        cfg_div = 0; cfg_smp = 0; cfg_res = 2; adc_result = 12'h123;
        wr_grp(2, 6, 1);
        trig();
        repeat (3) @(negedge clk);
        chk(busy == 0, "R4 no start from group2 or trigger", busy, 0);

        // R7 software restart of group 0 with a new channel
        L = lat(0, 0, 0, 2);
        wr_grp(0, 3, 1);
        repeat (5) @(negedge clk);
        wr_grp(0, 9, 0);
        push(drv_cyc + 1 + L, 0, 9, 12'h123, 0, "R7 sw restart");
        drain();

        // R5: hardware mode, load groups; writes must not start anything
        cfg_hwtrig = 1;
        wr_grp(0, 10, 1);
        wr_grp(1, 11, 0);
        wr_grp(2, 12, 1);
        wr_grp(3, 13, 0);
        repeat (2) @(negedge clk);
        chk(busy == 0, "R5 group writes do not start", busy, 0);

        // R5 R6 R8: first trigger, plus ignored trigger and foreign write mid-run
        trig();
        push(drv_cyc + 1 + L, 0, 10, 12'h123, 1, "R5 rr grp0");
        repeat (3) @(negedge clk);
        trig();
        wr_grp(2, 22, 1);
        chk(act_chan == 10, "R8 active channel unchanged", act_chan, 10);
        drain();
        trig();
        push(drv_cyc + 1 + L, 1, 11, 12'h123, 0, "R6 rr grp1 after ignored trigger");
        drain();
        trig();
        push(drv_cyc + 1 + L, 2, 22, 12'h123, 1, "R5 rr grp2");
        drain();
        trig();
        push(drv_cyc + 1 + L, 3, 13, 12'h123, 0, "R5 rr grp3");
        drain();
        trig();
        push(drv_cyc + 1 + L, 0, 10, 12'h123, 1, "R5 rr wrap grp0");
        drain();

        // R7 hardware abort by rewriting the active group (group 1)
        trig();
        repeat (4) @(negedge clk);
        wr_grp(1, 7, 0);
        chk(busy == 0, "R7 abort clears busy", busy, 0);
        repeat (40) @(negedge clk);
        chk(busy == 0, "R7 stays idle after abort", busy, 0);

        // R10 continuous mode in software mode
        cfg_hwtrig = 0; cfg_cont = 1; adc_result = 12'h456;
        wr_grp(0, 4, 1);
        begin
            int d0;
            d0 = drv_cyc + 1;
            push(d0 + L, 0, 4, 12'h456, 1, "R10 cont 1");
            push(d0 + 2 * L, 0, 4, 12'h456, 1, "R10 cont 2");
            push(d0 + 3 * L, 0, 4, 12'h456, 1, "R10 cont 3");
            while (cyc < d0 + L + 1) @(negedge clk);
            chk(busy == 1, "R10 busy held after done", busy, 1);
            while (cyc < d0 + 2 * L + 5) @(negedge clk);
            cfg_cont = 0;
        end
        drain();
        chk(busy == 0, "R10 stops after cont cleared", busy, 0);

        summary();
    end
endmodule